// File: doc/BRIEF.md
# PS/2 Keyboard Bring-Up Sequencer

This block brings a PS/2 keyboard to a working state after reset without any processor involvement. It drives a byte-wide transmit strobe into a PS/2 host port. It then collects the keyboard's reply bytes from that port's receive holding register. It walks a fixed script: keyboard reset, self-test check, disable, restore defaults, scan-set selection with its argument, and enable.

Each transmitted byte goes out only while the port reports an empty transmitter. After the strobe the sequencer waits a fixed number of cycles before it looks at the reply. Every command must be acknowledged. A resend request repeats the current byte a bounded number of times. A missing reply is caught by a programmable timeout. The block finishes with either a done flag, or an error flag plus the index of the step that failed. A start pulse reruns the whole script from the beginning at any time.

Top module: `kbd_init_seq`

## Requirements
- R1: While rst_n is low, done, error, tx_valid and rx_take are all 0. After rst_n goes high, the script starts by itself with no start pulse.
- R2: Commands go out in this step order: step 0 = 0xFF, step 2 = 0xF5, step 3 = 0xF6, step 4 = 0xF0, step 5 = 0x01, step 6 = 0xF4. Step 1 sends nothing and only awaits the self-test reply.
- R3: tx_valid is a one-cycle pulse, and it is raised only in the cycle after tx_empty was sampled high. While tx_empty stays low, nothing is sent.
- R4: The reply to a sent byte is read (rx_take) no earlier than DELAY_CYC cycles after the tx_valid pulse. rx_take is high only while rx_full is high, and only for one cycle per byte.
- R5: A reply of 0xFA to a command advances to the next step. After the 0xFA for step 0, the next received byte must be 0xAA.
- R6: Any self-test reply other than 0xAA sets error with fail_step = 1.
- R7: A reply of 0xFE to a command resends the same byte, up to MAX_RETRY (3) times per step. A further 0xFE sets error with fail_step = that step.
- R8: Any other unexpected reply to a command, including 0xFD, sets error with fail_step = the current step.
- R9: If rx_full stays low for more than timeout_lim consecutive cycles while a reply is awaited, error is set with fail_step = the current step.
- R10: done rises after the 0xFA for step 6. done and error are never both high. Once either is set, it holds along with fail_step, and no tx_valid or rx_take occurs until start.
- R11: A start pulse at any point, including after done or error, clears done and error and restarts from step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Restart pulse |
| timeout_lim | input | TO_W | Reply timeout in cycles |
| tx_empty | input | 1 | Port transmitter is empty |
| tx_valid | output | 1 | One-cycle send strobe |
| tx_byte | output | 8 | Byte to send |
| rx_full | input | 1 | Port holds a received byte |
| rx_byte | input | 8 | Received byte |
| rx_take | output | 1 | Consume the held byte |
| done | output | 1 | Script completed |
| error | output | 1 | Script failed |
| fail_step | output | 3 | Step index of the failure |

## Verification
The checker watches the handshake rules on every cycle: send strobes only after an empty transmitter, one-cycle strobes, reads only of a held byte, the minimum wait between a send and a read, exclusive and sticky done/error flags, and silence after completion. The command order, the resend limit, the self-test and diagnostic-failure paths, the timeout and the restart depend on what the keyboard answers. Only the bench's directed scenarios can show these, using a port model whose replies are scripted per command byte.

// File: rtl/kbd_init_pkg.sv
// Package: shared constants, state type and the command script for the
// keyboard bring-up sequencer. Assumes a script of at most 8 steps.
package kbd_init_pkg;

    localparam int STEP_W = 3;
    localparam logic [STEP_W-1:0] LAST_STEP = 3'd6;

    localparam logic [7:0] RSP_ACK    = 8'hFA;
    localparam logic [7:0] RSP_PASS   = 8'hAA;
    localparam logic [7:0] RSP_RESEND = 8'hFE;

    typedef struct packed {
        logic       sends;     // step transmits a byte
        logic [7:0] cmd;       // byte transmitted
        logic [7:0] want_rsp;  // reply that lets the step pass
    } step_t;

    typedef enum logic [2:0] {
        SQ_WAIT_TX,
        SQ_SEND,
        SQ_DELAY,
        SQ_REPLY,
        SQ_DONE,
        SQ_FAIL
    } seq_state_e;

    // Returns the script entry for a step index.
    function automatic step_t step_info(input logic [STEP_W-1:0] idx);
        step_t e;
        e = '{sends: 1'b1, cmd: 8'h00, want_rsp: RSP_ACK};
        case (idx)
            3'd0: e.cmd = 8'hFF;
            3'd1: e = '{sends: 1'b0, cmd: 8'h00, want_rsp: RSP_PASS};
            3'd2: e.cmd = 8'hF5;
            3'd3: e.cmd = 8'hF6;
            3'd4: e.cmd = 8'hF0;
            3'd5: e.cmd = 8'h01;
            3'd6: e.cmd = 8'hF4;
            default: e.cmd = 8'h00;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/kbd_script_rom.sv
// Script lookup: maps a step index to its command, reply and send flag.
// Assumes indices beyond the last step are never acted on.
module kbd_script_rom
    import kbd_init_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output step_t             entry
);

    // Combinational lookup into the fixed script.
    always_comb entry = step_info(step);

endmodule

// File: rtl/kbd_cycle_timer.sv
// Saturating cycle counter with synchronous clear, used for the post-send
// delay and for the reply timeout. Assumes clr has priority over en.
module kbd_cycle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);

    // Count up while enabled, hold at all-ones, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (en && count != '1)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/kbd_init_seq.sv
// Keyboard bring-up sequencer top. Walks the command script, sends each
// byte when the port transmitter is empty, waits DELAY_CYC cycles, then
// checks the reply. It retries on resend requests and times out a silent
// keyboard. Assumes the port clears rx_full in the cycle after rx_take.
module kbd_init_seq
    import kbd_init_pkg::*;
#(
    parameter int DELAY_CYC = 1000,
    parameter int TO_W      = 16,
    parameter int MAX_RETRY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TO_W-1:0]   timeout_lim,
    input  logic              tx_empty,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              rx_full,
    input  logic [7:0]        rx_byte,
    output logic              rx_take,
    output logic              done,
    output logic              error,
    output logic [STEP_W-1:0] fail_step
);

    localparam int DLY_W = $clog2(DELAY_CYC + 1);
    localparam int RTY_W = $clog2(MAX_RETRY + 1);
    localparam logic [DLY_W-1:0] DLY_END = DLY_W'(DELAY_CYC - 1);
    localparam logic [RTY_W-1:0] RTY_MAX = RTY_W'(MAX_RETRY);

    seq_state_e        state;
    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] step_nx;
    logic [RTY_W-1:0]  retry;
    step_t             cur;
    step_t             nxt;
    logic [DLY_W-1:0]  dly_cnt;
    logic [TO_W-1:0]   to_cnt;

    assign step_nx = step + 1'b1;

    kbd_script_rom u_cur_rom (.step(step),    .entry(cur));
    kbd_script_rom u_nxt_rom (.step(step_nx), .entry(nxt));

    kbd_cycle_timer #(.W(DLY_W)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == SQ_SEND),
        .en    (state == SQ_DELAY),
        .count (dly_cnt)
    );

    kbd_cycle_timer #(.W(TO_W)) u_timeout (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != SQ_REPLY || rx_full),
        .en    (state == SQ_REPLY),
        .count (to_cnt)
    );

    // Port-side strobes decoded from the state.
    always_comb begin
        tx_valid = (state == SQ_SEND);
        tx_byte  = cur.cmd;
        rx_take  = (state == SQ_REPLY) && rx_full;
    end

    // Script walker: state, step, retries and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            state     <= SQ_WAIT_TX;
            step      <= '0;
            retry     <= '0;
            done      <= 1'b0;
            error     <= 1'b0;
            fail_step <= '0;
        end else begin
            case (state)
                SQ_WAIT_TX: if (tx_empty) state <= SQ_SEND;
                SQ_SEND:    state <= SQ_DELAY;
                SQ_DELAY:   if (dly_cnt == DLY_END) state <= SQ_REPLY;
                SQ_REPLY: begin
                    if (rx_full) begin
                        if (rx_byte == cur.want_rsp) begin
                            retry <= '0;
                            if (step == LAST_STEP) begin
                                state <= SQ_DONE;
                                done  <= 1'b1;
                            end else begin
                                step  <= step_nx;
                                state <= nxt.sends ? SQ_WAIT_TX : SQ_REPLY;
                            end
                        end else if (cur.sends && rx_byte == RSP_RESEND
                                     && retry < RTY_MAX) begin
                            retry <= retry + 1'b1;
                            state <= SQ_WAIT_TX;
                        end else begin
                            state     <= SQ_FAIL;
                            error     <= 1'b1;
                            fail_step <= step;
                        end
                    end else if (to_cnt == timeout_lim) begin
                        state     <= SQ_FAIL;
                        error     <= 1'b1;
                        fail_step <= step;
                    end
                end
                default: state <= state;
            endcase
        end
    end

endmodule

// File: rtl/kbd_init_seq_chk.sv
// Protocol checker for the bring-up sequencer, bound to the top module.
// Assumes the port model follows the rx_take / rx_full handshake.
module kbd_init_seq_chk #(
    parameter int DELAY_CYC = 1000,
    parameter int TO_W      = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [TO_W-1:0] timeout_lim,
    input logic            tx_empty,
    input logic            tx_valid,
    input logic [7:0]      tx_byte,
    input logic            rx_full,
    input logic [7:0]      rx_byte,
    input logic            rx_take,
    input logic            done,
    input logic            error,
    input logic [2:0]      fail_step
);

    logic [31:0] since_tx;

    // Cycles since the last send strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_tx <= '1;
        else if (tx_valid)
            since_tx <= '0;
        else if (since_tx != '1)
            since_tx <= since_tx + 1'b1;
    end

    // R3
    tx_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_empty));

    // R3
    tx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    // R4
    take_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> rx_full);

    // R4
    reply_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> since_tx >= 32'(DELAY_CYC));

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> (error && $stable(fail_step)));

    // R10
    quiet_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (!tx_valid && !rx_take));

    // R8
    fail_step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> fail_step <= 3'd6);

endmodule

bind kbd_init_seq kbd_init_seq_chk #(.DELAY_CYC(DELAY_CYC), .TO_W(TO_W)) u_chk (.*);

// File: tb/kbd_init_seq_bench.sv
// Directed bench with a behavioural port/keyboard model whose replies are
// scripted per command byte.
module kbd_init_seq_bench;

    localparam int DELAY = 1000;

    logic       clk = 1'b0;
    logic       rst_n, start, tx_empty, rx_full, tx_valid, rx_take, done, error;
    logic [7:0] rx_byte, tx_byte;
    logic [15:0] timeout_lim;
    logic [2:0] fail_step;

    int n_tests = 0;
    int n_fail  = 0;

    // Keyboard model configuration
    logic [7:0] fe_byte, silent_byte, bad_byte, bad_val, st_val;
    int         fe_left;
    logic       silent_en, bad_en;

    // Model state
    logic [7:0] sent [0:31];
    int         nsent;
    logic [7:0] q [0:7];
    int         qn;
    longint     cyc = 0;
    longint     last_tx;
    longint     min_gap;

    always #5 clk = ~clk;

    kbd_init_seq u_kbd_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_lim(timeout_lim),
        .tx_empty(tx_empty), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .rx_full(rx_full), .rx_byte(rx_byte), .rx_take(rx_take),
        .done(done), .error(error), .fail_step(fail_step)
    );

    // Port and keyboard model: logs sends, queues replies, serves reads.
    always @(posedge clk) begin
        if (!rst_n) begin
            qn = 0; nsent = 0; min_gap = 64'd1000000; last_tx = 0;
        end else if (start) begin
            qn = 0;
        end else begin
            if (rx_take && qn > 0) begin
                for (int i = 0; i < 7; i++) q[i] = q[i+1];
                qn = qn - 1;
                if (cyc - last_tx < min_gap) min_gap = cyc - last_tx;
            end
            if (tx_valid) begin
                if (nsent < 32) sent[nsent] = tx_byte;
                nsent = nsent + 1;
                last_tx = cyc;
                if (tx_byte == fe_byte && fe_left > 0) begin
                    fe_left = fe_left - 1;
                    if (qn < 8) begin q[qn] = 8'hFE; qn = qn + 1; end
                end else if (silent_en && tx_byte == silent_byte) begin
                    qn = qn;
                end else if (bad_en && tx_byte == bad_byte) begin
                    if (qn < 8) begin q[qn] = bad_val; qn = qn + 1; end
                end else begin
                    if (qn < 8) begin q[qn] = 8'hFA; qn = qn + 1; end
                    if (tx_byte == 8'hFF && qn < 8) begin q[qn] = st_val; qn = qn + 1; end
                end
            end
        end
        rx_full <= (qn > 0);
        rx_byte <= q[0];
        cyc = cyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        fe_byte = 8'h00; fe_left = 0; silent_en = 1'b0; silent_byte = 8'h00;
        bad_en = 1'b0; bad_byte = 8'h00; bad_val = 8'h00; st_val = 8'hAA;
        timeout_lim = 16'd20; tx_empty = 1'b1; start = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_end();
        int n = 0;
        while (!(done || error) && n < 30000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int count_byte(input logic [7:0] b);
        int c = 0;
        for (int i = 0; i < nsent && i < 32; i++) if (sent[i] == b) c++;
        return c;
    endfunction

    task automatic t_reset();
        fe_byte = 8'h00; fe_left = 0; silent_en = 1'b0; bad_en = 1'b0;
        st_val = 8'hAA; timeout_lim = 16'd20; tx_empty = 1'b1; start = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && !error, "R1", "flags in reset", {done, error}, 0);
        check(!tx_valid && !rx_take, "R1", "strobes in reset", {tx_valid, rx_take}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(nsent == 1 && sent[0] == 8'hFF, "R1", "self start first byte", sent[0], 8'hFF);
    endtask

    task automatic t_normal();
        logic [7:0] exp_seq [0:5] = '{8'hFF, 8'hF5, 8'hF6, 8'hF0, 8'h01, 8'hF4};
        bit seq_ok = 1'b1;
        apply_reset();
        wait_end();
        check(done && !error, "R5", "normal run done", {done, error}, 2);
        check(nsent == 6, "R2", "bytes sent", nsent, 6);
        for (int i = 0; i < 6; i++) if (sent[i] != exp_seq[i]) seq_ok = 1'b0;
        check(seq_ok, "R2", "command order", seq_ok, 1);
        check(min_gap >= DELAY, "R4", "send to read gap", min_gap, DELAY);
    endtask

    task automatic t_tx_gate();
        apply_reset();
        tx_empty = 1'b0;
        repeat (200) @(negedge clk);
        check(nsent == 0, "R3", "sends while tx busy", nsent, 0);
        tx_empty = 1'b1;
        wait_end();
        check(done && nsent == 6, "R3", "run after tx frees", nsent, 6);
    endtask

    task automatic t_resend_ok();
        apply_reset();
        fe_byte = 8'hF6; fe_left = 3;
        wait_end();
        check(done && !error, "R7", "three resends tolerated", {done, error}, 2);
        check(count_byte(8'hF6) == 4, "R7", "F6 send count", count_byte(8'hF6), 4);
    endtask

    task automatic t_resend_fail();
        apply_reset();
        fe_byte = 8'hF6; fe_left = 4;
        wait_end();
        check(error && fail_step == 3'd3, "R7", "fourth resend fails step", fail_step, 3);
        check(count_byte(8'hF6) == 4, "R7", "F6 sends before fail", count_byte(8'hF6), 4);
    endtask

    task automatic t_selftest_bad();
        apply_reset();
        st_val = 8'h55;
        wait_end();
        check(error && fail_step == 3'd1, "R6", "bad self-test step", fail_step, 1);
        check(nsent == 1, "R6", "sends before self-test fail", nsent, 1);
    endtask

    task automatic t_diag();
        apply_reset();
        bad_en = 1'b1; bad_byte = 8'h01; bad_val = 8'hFD;
        wait_end();
        check(error && !done && fail_step == 3'd5, "R8", "FD reply step", fail_step, 5);
    endtask

    task automatic t_timeout();
        apply_reset();
        silent_en = 1'b1; silent_byte = 8'hF0;
        wait_end();
        check(error && fail_step == 3'd4, "R9", "silent keyboard step", fail_step, 4);
        check(nsent == 4, "R9", "sends before timeout", nsent, 4);
    endtask

    task automatic t_hold();
        int k;
        apply_reset();
        wait_end();
        k = nsent;
        repeat (300) @(negedge clk);
        check(done && !error, "R10", "done held", {done, error}, 2);
        check(nsent == k, "R10", "no traffic after done", nsent, k);
    endtask

    task automatic t_restart();
        int k;
        int n = 0;
        apply_reset();
        while (nsent < 3 && n < 20000) begin @(negedge clk); n++; end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = nsent;
        wait_end();
        check(done && sent[k] == 8'hFF, "R11", "restart begins at reset cmd", sent[k], 8'hFF);
        check(nsent == k + 6, "R11", "full script after restart", nsent, k + 6);
        apply_reset();
        st_val = 8'h55;
        wait_end();
        check(error, "R11", "error before restart", error, 1);
        st_val = 8'hAA;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!error && !done, "R11", "flags cleared by start", {done, error}, 0);
        wait_end();
        check(done && !error, "R11", "done after restart", {done, error}, 2);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_tx_gate();
        t_resend_ok();
        t_resend_fail();
        t_selftest_bad();
        t_diag();
        t_timeout();
        t_hold();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL all watchdog expired: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule